// File: doc/BRIEF.md
# Wake-up frame detector

This block watches the byte stream of received Ethernet frames and recognises wake-up frames meant for the station. The stream carries a start-of-frame marker on the first byte and a separate end-of-frame strobe with a frame-good flag from the upstream CRC check.

A frame qualifies when two conditions hold. First, its destination address passes the filter. Second, somewhere after the destination its payload holds a run of six 0xFF bytes followed at once by sixteen back-to-back copies of the 48-bit station address. When a qualifying, error-free frame ends while detection is armed, a sticky flag is set. That flag drives an interrupt output through two enables.

A host programs the block through a small register port. The port has an address, a write enable, write data and combinational read data. The station address sits in three 16-bit words. The control word holds the mode, enable, any-destination permission, interrupt enable and the write-1-to-clear flag. A second permission bit sits in its own extension word. A power-good input can arm detection in place of the enable bit. A stop input clears the flag, and a software reset input clears the control state.

Top module: `wake_frame_detector`

## Requirements
- R1: With both permission bits clear, a frame qualifies only if its six destination bytes equal the station address. Wire byte k is station bit field [8k+7:8k]. Word 1 holds bytes 0 (low) and 1, word 2 holds bytes 2 and 3, word 3 holds bytes 4 and 5.
- R2: If control bit 2 or extension word (address 4) bit 0 is 1, any destination qualifies: station, other unicast, multicast or broadcast. The payload rule still applies.
- R3: The payload after the destination must contain six consecutive 0xFF bytes followed directly by sixteen consecutive copies of the station address in wire order. Fifteen copies do not qualify.
- R4: The search restarts on any mismatching byte. If that byte is 0xFF, it counts as the first byte of a new sync run.
- R5: Detection is armed only when control bit 0 (mode) is 1 and either the power_good input or control bit 1 (enable) is 1. A qualifying frame seen while not armed leaves the flag clear.
- R6: The flag (control bit 5) is set only in the cycle after an end-of-frame strobe with rx_good high. A frame that ends with rx_good low leaves it clear.
- R7: Writing control with bit 5 set clears the flag. Writing bit 5 as 0 leaves the flag unchanged.
- R8: A stop pulse clears the flag. It leaves the mode, enable, permission and interrupt-enable bits and the station address unchanged.
- R9: A soft_rst pulse clears the control bits, the extension bit and the flag, and keeps the station address. Hardware reset clears everything.
- R10: irq is high exactly when the flag, control bit 4 (interrupt enable) and the global_irq_en input are all 1.
- R11: Reads return the register contents without side effects. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset |
| stop | input | 1 | Stop control, clears the flag |
| power_good | input | 1 | Arms detection together with mode |
| global_irq_en | input | 1 | Global interrupt enable |
| rx_valid | input | 1 | rx_data carries a byte |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | End-of-frame strobe (no byte in that cycle) |
| rx_good | input | 1 | Frame passed CRC, valid with rx_eof |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| irq | output | 1 | Interrupt output |

## Verification
A wrong internal state shows up at the flag bit and at irq one cycle after the end-of-frame strobe. A stuck sync counter, a copy count that is off by one, or a destination match that is not cleared between frames will set the flag wrongly or miss a frame, and this is seen at the very next frame end. A restart that drops a 0xFF mismatch loses the frame that the recovery sequence carries. Control bits that a stop pulse disturbs become visible on the next read of the control word.

// File: rtl/wfd_pkg.sv
package wfd_pkg;
   localparam int MAC_BYTES = 6;
   localparam int MAC_W     = 8 * MAC_BYTES;
   localparam int REG_W     = 16;
   localparam int REG_AW    = 3;

   localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
   localparam logic [REG_AW-1:0] A_STA0 = 3'd1;
   localparam logic [REG_AW-1:0] A_STA1 = 3'd2;
   localparam logic [REG_AW-1:0] A_STA2 = 3'd3;
   localparam logic [REG_AW-1:0] A_EXT  = 3'd4;

   localparam int B_MODE  = 0;
   localparam int B_EN    = 1;
   localparam int B_ANY   = 2;
   localparam int B_IRQEN = 4;
   localparam int B_FLAG  = 5;

   typedef enum logic {PH_SYNC, PH_COPY} phase_t;
endpackage

// File: rtl/wfd_regs.sv
module wfd_regs
   import wfd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              stop,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              set_flag,
   output logic              mode,
   output logic              enable,
   output logic              any_dest,
   output logic              ext_any,
   output logic              irq_en,
   output logic              flag,
   output logic [MAC_W-1:0]  station
);
   logic wr_ctrl;
   assign wr_ctrl = reg_we && (reg_addr == A_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= 1'b0; enable <= 1'b0; any_dest <= 1'b0;
         irq_en <= 1'b0; ext_any <= 1'b0;
      end else if (soft_rst) begin
         mode <= 1'b0; enable <= 1'b0; any_dest <= 1'b0;
         irq_en <= 1'b0; ext_any <= 1'b0;
      end else if (reg_we) begin
         if (reg_addr == A_CTRL) begin
            mode     <= reg_wdata[B_MODE];
            enable   <= reg_wdata[B_EN];
            any_dest <= reg_wdata[B_ANY];
            irq_en   <= reg_wdata[B_IRQEN];
         end
         if (reg_addr == A_EXT) ext_any <= reg_wdata[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (soft_rst || stop)
         flag <= 1'b0;
      else if (set_flag)
         flag <= 1'b1;
      else if (wr_ctrl && reg_wdata[B_FLAG])
         flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         station <= '0;
      else if (reg_we && !soft_rst) begin
         case (reg_addr)
            A_STA0:  station[15:0]  <= reg_wdata;
            A_STA1:  station[31:16] <= reg_wdata;
            A_STA2:  station[47:32] <= reg_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[B_MODE]  = mode;
            reg_rdata[B_EN]    = enable;
            reg_rdata[B_ANY]   = any_dest;
            reg_rdata[B_IRQEN] = irq_en;
            reg_rdata[B_FLAG]  = flag;
         end
         A_STA0:  reg_rdata = station[15:0];
         A_STA1:  reg_rdata = station[31:16];
         A_STA2:  reg_rdata = station[47:32];
         A_EXT:   reg_rdata[0] = ext_any;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wfd_dest_filter.sv
module wfd_dest_filter
   import wfd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic             rx_sof,
   input  logic [7:0]       rx_data,
   input  logic             rx_eof,
   input  logic [MAC_W-1:0] station,
   input  logic             any_ok,
   output logic             payload_vld,
   output logic             dest_ok
);
   localparam int PW = $clog2(MAC_BYTES + 1);
   localparam logic [PW-1:0] POS_END = PW'(MAC_BYTES);

   logic          in_frame;
   logic [PW-1:0] pos_q;
   logic          match_q;
   logic          first;
   logic          take;
   logic [PW-1:0] idx;
   logic          byte_eq;

   assign first = rx_valid && rx_sof && !rx_eof;
   assign take  = rx_valid && !rx_eof && (first || in_frame);
   assign idx   = first ? '0 : pos_q;
   assign byte_eq = (idx < POS_END) &&
                    (rx_data == station[8*idx[2:0] +: 8]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         pos_q    <= '0;
         match_q  <= 1'b0;
      end else if (rx_eof) begin
         in_frame <= 1'b0;
         pos_q    <= '0;
         match_q  <= 1'b0;
      end else if (take) begin
         in_frame <= 1'b1;
         if (idx < POS_END) begin
            pos_q   <= idx + 1'b1;
            match_q <= (first ? 1'b1 : match_q) && byte_eq;
         end
      end
   end

   assign payload_vld = take && !first && (pos_q == POS_END);
   assign dest_ok     = (pos_q == POS_END) && (match_q || any_ok);
endmodule

// File: rtl/wfd_pattern_search.sv
module wfd_pattern_search
   import wfd_pkg::*;
#(
   parameter int SYNC_LEN = 6,
   parameter int COPIES   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             vld,
   input  logic [7:0]       data,
   input  logic [MAC_W-1:0] station,
   output logic             found
);
   localparam int SW = $clog2(SYNC_LEN + 1);
   localparam int CW = (COPIES > 1) ? $clog2(COPIES) : 1;
   localparam logic [SW-1:0] SYNC_FULL = SW'(SYNC_LEN);
   localparam logic [CW-1:0] COPY_LAST = CW'(COPIES - 1);
   localparam logic [2:0]    IDX_LAST  = 3'(MAC_BYTES - 1);

   phase_t        phase;
   logic [SW-1:0] sync_cnt;
   logic [2:0]    bidx;
   logic [CW-1:0] copy_cnt;
   logic          is_ff;
   logic          exp_eq;

   assign is_ff  = (data == 8'hFF);
   assign exp_eq = (data == station[8*bidx +: 8]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || clr) begin
         if (!rst_n || clr) begin
            phase    <= PH_SYNC;
            sync_cnt <= '0;
            bidx     <= '0;
            copy_cnt <= '0;
            found    <= 1'b0;
         end
      end else if (vld && !found) begin
         case (phase)
            PH_SYNC: begin
               if (sync_cnt == SYNC_FULL && data == station[7:0]) begin
                  phase    <= PH_COPY;
                  bidx     <= 3'd1;
                  copy_cnt <= '0;
               end else if (is_ff) begin
                  if (sync_cnt != SYNC_FULL) sync_cnt <= sync_cnt + 1'b1;
               end else begin
                  sync_cnt <= '0;
               end
            end
            PH_COPY: begin
               if (exp_eq) begin
                  if (bidx == IDX_LAST) begin
                     bidx <= '0;
                     if (copy_cnt == COPY_LAST) found <= 1'b1;
                     else copy_cnt <= copy_cnt + 1'b1;
                  end else begin
                     bidx <= bidx + 1'b1;
                  end
               end else begin
                  phase    <= PH_SYNC;
                  sync_cnt <= is_ff ? SW'(1) : '0;
                  bidx     <= '0;
               end
            end
            default: phase <= PH_SYNC;
         endcase
      end
   end
endmodule

// File: rtl/wake_frame_detector.sv
module wake_frame_detector
   import wfd_pkg::*;
#(
   parameter int SYNC_LEN       = 6,
   parameter int COPIES         = 16,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              stop,
   input  logic              power_good,
   input  logic              global_irq_en,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic [7:0]        rx_data,
   input  logic              rx_eof,
   input  logic              rx_good,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq
);
   if (SYNC_LEN < 1 || SYNC_LEN > 15) begin : g_bad_sync
      $error("SYNC_LEN must lie in 1..15");
   end
   if (COPIES < 1 || COPIES > 64) begin : g_bad_copies
      $error("COPIES must lie in 1..64");
   end

   logic             mode_w, enable_w, any_w, ext_w, irq_en_w, flag_w;
   logic [MAC_W-1:0] station_w;
   logic             payload_vld, dest_ok, found, armed, set_flag;

   assign armed    = mode_w && (power_good || enable_w);
   assign set_flag = rx_eof && rx_good && armed && dest_ok && found;

   wfd_regs u_regs (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .set_flag(set_flag),
      .mode(mode_w), .enable(enable_w), .any_dest(any_w), .ext_any(ext_w),
      .irq_en(irq_en_w), .flag(flag_w), .station(station_w)
   );

   wfd_dest_filter u_dest (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
      .rx_data(rx_data), .rx_eof(rx_eof), .station(station_w),
      .any_ok(any_w || ext_w), .payload_vld(payload_vld), .dest_ok(dest_ok)
   );

   wfd_pattern_search #(.SYNC_LEN(SYNC_LEN), .COPIES(COPIES)) u_search (
      .clk(clk), .rst_n(rst_n),
      .clr((rx_valid && rx_sof && !rx_eof) || rx_eof),
      .vld(payload_vld), .data(rx_data), .station(station_w), .found(found)
   );

   if (IRQ_REGISTERED) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= flag_w && irq_en_w && global_irq_en;
      end
   end else begin : g_irq_comb
      assign irq = flag_w && irq_en_w && global_irq_en;
   end
endmodule

// File: rtl/wfd_checker.sv
module wfd_checker
   import wfd_pkg::*;
#(
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic              stop,
   input logic              power_good,
   input logic              global_irq_en,
   input logic              rx_eof,
   input logic              rx_good,
   input logic [REG_AW-1:0] reg_addr,
   input logic              reg_we,
   input logic [REG_W-1:0]  reg_wdata,
   input logic              mode,
   input logic              enable,
   input logic              any_dest,
   input logic              irq_en,
   input logic              flag,
   input logic              irq
);
   a_r6_set_at_good_eof: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(rx_eof && rx_good));

   a_r5_set_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(mode && (power_good || enable)));

   a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_CTRL && reg_wdata[B_FLAG] && !rx_eof) |=> !flag);

   a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !flag);

   a_r8_stop_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !soft_rst && !reg_we) |=> $stable(mode) && $stable(irq_en));

   a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !mode && !enable && !any_dest && !irq_en && !flag);

   if (IRQ_REGISTERED) begin : g_reg
      a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> $past(flag && irq_en && global_irq_en));
   end else begin : g_comb
      a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> (flag && irq_en && global_irq_en));
   end
endmodule

bind wake_frame_detector wfd_checker #(.IRQ_REGISTERED(IRQ_REGISTERED)) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop),
   .power_good(power_good), .global_irq_en(global_irq_en),
   .rx_eof(rx_eof), .rx_good(rx_good), .reg_addr(reg_addr), .reg_we(reg_we),
   .reg_wdata(reg_wdata), .mode(mode_w), .enable(enable_w), .any_dest(any_w),
   .irq_en(irq_en_w), .flag(flag_w), .irq(irq)
);

// File: tb/tb_wake_frame_detector.sv
module tb_wake_frame_detector;
   localparam int CLK_PERIOD = 10;
   localparam logic [47:0] STA   = 48'h07_9E_22_C4_13_5A;
   localparam logic [47:0] OTHER = 48'h66_55_44_33_22_02;
   localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
   localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_01;

   // entry: dest_sel[10:9], any[8], ext[7], copies[6:2], good[1], expect[0]
   localparam logic [10:0] VEC [9] = '{
      {2'd0, 1'b0, 1'b0, 5'd16, 1'b1, 1'b1},
      {2'd1, 1'b0, 1'b0, 5'd16, 1'b1, 1'b0},
      {2'd2, 1'b0, 1'b0, 5'd16, 1'b1, 1'b0},
      {2'd2, 1'b1, 1'b0, 5'd16, 1'b1, 1'b1},
      {2'd3, 1'b0, 1'b1, 5'd16, 1'b1, 1'b1},
      {2'd1, 1'b1, 1'b1, 5'd16, 1'b1, 1'b1},
      {2'd0, 1'b0, 1'b0, 5'd15, 1'b1, 1'b0},
      {2'd2, 1'b1, 1'b0, 5'd15, 1'b1, 1'b0},
      {2'd0, 1'b0, 1'b0, 5'd16, 1'b0, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, stop = 1'b0;
   logic power_good = 1'b0, global_irq_en = 1'b0;
   logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
   logic [7:0] rx_data = '0;
   logic [2:0] reg_addr = '0;
   logic reg_we = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic irq;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   wake_frame_detector dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop),
      .power_good(power_good), .global_irq_en(global_irq_en),
      .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
      .rx_eof(rx_eof), .rx_good(rx_good), .reg_addr(reg_addr),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put(input logic [7:0] b, input logic s);
      rx_valid = 1'b1; rx_data = b; rx_sof = s;
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0;
   endtask

   task automatic finish_frame(input logic good);
      rx_eof = 1'b1; rx_good = good;
      @(negedge clk);
      rx_eof = 1'b0; rx_good = 1'b0;
   endtask

   task automatic head(input logic [47:0] dest);
      for (int i = 0; i < 6; i++) put(dest[8*i +: 8], i == 0);
      for (int i = 0; i < 6; i++) put(8'h10 + 8'(i), 1'b0);
      put(8'h08, 1'b0); put(8'h42, 1'b0);
   endtask

   task automatic copies(input int n);
      for (int c = 0; c < n; c++)
         for (int i = 0; i < 6; i++) put(STA[8*i +: 8], 1'b0);
   endtask

   task automatic frame(input logic [47:0] dest, input int n, input logic good);
      head(dest);
      for (int i = 0; i < 6; i++) put(8'hFF, 1'b0);
      copies(n);
      put(8'h00, 1'b0); put(8'h11, 1'b0);
      finish_frame(good);
   endtask

   function automatic logic flag_of(input logic [15:0] v);
      return v[5];
   endfunction

   initial begin
      logic [15:0] v;
      logic [47:0] d;
      repeat (3) @(negedge clk);
      rd(3'd0, v); check("R9 reset control word", v, 16'h0000);
      check("R10 reset irq", {15'b0, irq}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      wr(3'd1, STA[15:0]); wr(3'd2, STA[31:16]); wr(3'd3, STA[47:32]);
      rd(3'd2, v); check("R11 station word readback", v, STA[31:16]);
      rd(3'd5, v); check("R11 unused address", v, 16'h0000);

      for (int e = 0; e < 9; e++) begin
         case (VEC[e][10:9])
            2'd0: d = STA;
            2'd1: d = OTHER;
            2'd2: d = BCAST;
            default: d = MCAST;
         endcase
         wr(3'd0, 16'h0023 | (VEC[e][8] ? 16'h0004 : 16'h0));
         wr(3'd4, {15'b0, VEC[e][7]});
         frame(d, int'(VEC[e][6:2]), VEC[e][1]);
         rd(3'd0, v);
         check($sformatf("R1/R2/R3/R6 table entry %0d", e), {15'b0, flag_of(v)},
               {15'b0, VEC[e][0]});
      end
      wr(3'd4, 16'h0);

      // R4: broken sequence, FF at mismatch starts a new sync run
      wr(3'd0, 16'h0023);
      head(STA);
      for (int i = 0; i < 6; i++) put(8'hFF, 1'b0);
      for (int i = 0; i < 3; i++) put(STA[8*i +: 8], 1'b0);
      for (int i = 0; i < 6; i++) put(8'hFF, 1'b0);
      copies(16);
      finish_frame(1'b1);
      rd(3'd0, v); check("R4 restart inside failed sequence", {15'b0, flag_of(v)}, 16'h1);

      // R4: non-FF mismatch restarts; 5 FF afterwards is too short
      wr(3'd0, 16'h0023);
      head(STA);
      for (int i = 0; i < 6; i++) put(8'hFF, 1'b0);
      for (int i = 0; i < 2; i++) put(STA[8*i +: 8], 1'b0);
      put(8'h00, 1'b0);
      for (int i = 0; i < 5; i++) put(8'hFF, 1'b0);
      copies(16);
      finish_frame(1'b1);
      rd(3'd0, v); check("R4 short sync after restart", {15'b0, flag_of(v)}, 16'h0);

      // R5: mode clear
      wr(3'd0, 16'h0022);
      frame(STA, 16, 1'b1);
      rd(3'd0, v); check("R5 mode clear blocks", {15'b0, flag_of(v)}, 16'h0);
      // R5: mode set, enable clear, no power-good
      wr(3'd0, 16'h0021);
      frame(STA, 16, 1'b1);
      rd(3'd0, v); check("R5 not armed", {15'b0, flag_of(v)}, 16'h0);
      // R5: power-good arms
      power_good = 1'b1;
      frame(STA, 16, 1'b1);
      rd(3'd0, v); check("R5 power-good arms", {15'b0, flag_of(v)}, 16'h1);
      power_good = 1'b0;

      // R10 irq gating, flag set, irq_en = 0
      global_irq_en = 1'b1;
      #1 check("R10 irq off without source enable", {15'b0, irq}, 16'h0);
      wr(3'd0, 16'h0011);
      check("R10 irq on with both enables", {15'b0, irq}, 16'h1);
      global_irq_en = 1'b0;
      #1 check("R10 irq off without global enable", {15'b0, irq}, 16'h0);

      // R7 write 0 keeps, write 1 clears
      wr(3'd0, 16'h0013);
      rd(3'd0, v); check("R7 write zero keeps flag", v, 16'h0033);
      wr(3'd0, 16'h0033);
      rd(3'd0, v); check("R7 write one clears flag", v, 16'h0013);

      // R8 stop
      wr(3'd0, 16'h0017);
      frame(STA, 16, 1'b1);
      rd(3'd0, v); check("R8 flag before stop", v, 16'h0037);
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      rd(3'd0, v); check("R8 stop clears only flag", v, 16'h0017);

      // R9 soft reset
      frame(STA, 16, 1'b1);
      wr(3'd4, 16'h0001);
      soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
      rd(3'd0, v); check("R9 soft reset clears control", v, 16'h0000);
      rd(3'd4, v); check("R9 soft reset clears extension", v, 16'h0000);
      rd(3'd3, v); check("R9 soft reset keeps station", v, STA[47:32]);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule